// File: doc/BRIEF.md
# Timed Power Rail Sequencer

This controller brings up three regulator rails one at a time on a fixed schedule and then lets the rest of the system out of reset. After a global reset it counts a programmed delay and then enables rail 1. It does the same for rail 2 and then rail 3, each with its own delay. After that it waits a settle time and samples three power-good lines. If all three are good, it waits a release delay and drives the system reset output high.

While the system runs, the controller watches the power-good lines and an active-low shutdown request. A lost power-good latches a fault. A shutdown request takes the rails down in the same order and with the same per-rail delays as power-up. System reset drops when the last rail turns off, and the controller then stays idle until the next global reset.

Delays are counted in ticks. A prescaler restarted at the start of every interval makes one tick from `TICK_DIV` clock cycles, so each interval is exactly its tick count times `TICK_DIV` cycles.

Top module: `rail_sequencer`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, `rail_en` is 000, `sys_reset_n` is 0 and `fault` is 0.
- R2: Rails turn on in the order `rail_en[0]` (rail 1), `rail_en[1]` (rail 2), `rail_en[2]` (rail 3). Rail 1 rises exactly `DLY_RAIL1*TICK_DIV` cycles after the first clock edge with `rst` low. Each later rail rises `DLY_RAILk*TICK_DIV` cycles after the previous rail.
- R3: The delay counter and prescaler restart from zero for every interval. The default delays are 4000, 3000 and 3500 ticks for rails 1, 2 and 3.
- R4: `DLY_SETTLE*TICK_DIV` cycles after rail 3 turns on, the synchronized power-good lines are sampled. If any is low, `fault` goes high in that cycle, `sys_reset_n` stays low and all enables stay high.
- R5: If all three are high at that sample, `sys_reset_n` goes high `DLY_RELEASE*TICK_DIV` cycles later. The controller is then running.
- R6: While running, a low power-good line sets `fault` and clears `sys_reset_n`. The enables are held. Power-good loss takes priority over a shutdown request in the same cycle.
- R7: `fault` and the held enables stay as they are until `rst`, whatever the inputs do.
- R8: While running, a low `shutdown_n` starts power-down. `rail_en[0]` falls after `DLY_RAIL1*TICK_DIV` cycles, then `rail_en[1]` after `DLY_RAIL2*TICK_DIV`, then `rail_en[2]` after `DLY_RAIL3*TICK_DIV`. `sys_reset_n` falls in the same cycle as `rail_en[2]`.
- R9: A shutdown request made before the running state has no effect until the running state is reached. It is then acted on in the next cycle.
- R10: After power-down the outputs stay at `rail_en`=000, `sys_reset_n`=0, `fault`=0 until `rst`, whatever the inputs do.
- R11: `pwr_good` and `shutdown_n` pass through two flip-flops. A change applied before clock edge a is acted on by the controller at edge a+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high global reset |
| pwr_good | input | 3 | Power-good per rail, bit k-1 for rail k, high is good |
| shutdown_n | input | 1 | Active-low power-down request |
| rail_en | output | 3 | Regulator enables, bit k-1 for rail k |
| sys_reset_n | output | 1 | System reset, high releases the system |
| fault | output | 1 | Latched power-good fault flag |

## Verification
The embedded assertions check the following on every cycle:
- the reset values;
- the rise order of the enables and the fall order of the enables;
- that reset is released only with all rails on and no fault;
- that a fault freezes the enables;
- that the tick counter stays below its limit.

Only the bench scenarios can show the exact cycle counts of each interval and the two-cycle input latency. The same holds for the choice between fault and release at the settle sample, the priority of fault over shutdown, and that early shutdown requests and post-power-down inputs are ignored.

// File: rtl/rail_seq_pkg.sv
package rail_seq_pkg;

  typedef enum logic [3:0] {
    ST_ON1,
    ST_ON2,
    ST_ON3,
    ST_SETTLE,
    ST_HOLDOFF,
    ST_RUN,
    ST_OFF1,
    ST_OFF2,
    ST_OFF3,
    ST_IDLE,
    ST_FAULT
  } seq_state_t;

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/rail_seq_sync.sv
module rail_seq_sync #(
  parameter int unsigned W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= RST_VAL;
      sync_q <= RST_VAL;
    end else begin
      meta_q <= d;
      sync_q <= meta_q;
    end
  end

  assign q = sync_q;

endmodule

// File: rtl/rail_seq_timer.sv
module rail_seq_timer #(
  parameter int unsigned TICK_DIV = 200,
  parameter int unsigned CW       = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic [CW-1:0] limit,
  output logic          done
);

  localparam int unsigned PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

  logic [PW-1:0] pre_q;
  logic [CW-1:0] ticks_q;
  logic          tick_end;

  assign tick_end = (pre_q == PW'(TICK_DIV - 1));
  assign done     = run && tick_end && (ticks_q == limit - CW'(1));

  always_ff @(posedge clk) begin
    if (rst || !run || done) begin
      pre_q   <= '0;
      ticks_q <= '0;
    end else if (tick_end) begin
      pre_q   <= '0;
      ticks_q <= ticks_q + CW'(1);
    end else begin
      pre_q <= pre_q + PW'(1);
    end
  end

  // R3: an interval never counts past its programmed limit
  a_r3_tick_bound: assert property (@(posedge clk) disable iff (rst)
    run |-> (ticks_q < limit));

  // R3: prescaler stays inside one tick
  a_r3_pre_bound: assert property (@(posedge clk) disable iff (rst)
    32'(pre_q) < TICK_DIV);

endmodule

// File: rtl/rail_sequencer.sv
module rail_sequencer
  import rail_seq_pkg::*;
#(
  parameter int unsigned TICK_DIV    = 200,
  parameter int unsigned DLY_RAIL1   = 4000,
  parameter int unsigned DLY_RAIL2   = 3000,
  parameter int unsigned DLY_RAIL3   = 3500,
  parameter int unsigned DLY_SETTLE  = 2000,
  parameter int unsigned DLY_RELEASE = 2000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] pwr_good,
  input  logic       shutdown_n,
  output logic [2:0] rail_en,
  output logic       sys_reset_n,
  output logic       fault
);

  localparam int unsigned MAX_RAIL = max_u(max_u(DLY_RAIL1, DLY_RAIL2), DLY_RAIL3);
  localparam int unsigned MAX_DLY  = max_u(MAX_RAIL, max_u(DLY_SETTLE, DLY_RELEASE));
  localparam int unsigned CW       = $clog2(MAX_DLY + 1);

  seq_state_t    state_q;
  logic [2:0]    pg_s;
  logic          shdn_s;
  logic          tmr_run;
  logic          tmr_done;
  logic [CW-1:0] tmr_limit;

  rail_seq_sync #(.W(3), .RST_VAL(3'b000)) u_pg_sync (
    .clk (clk),
    .rst (rst),
    .d   (pwr_good),
    .q   (pg_s)
  );

  rail_seq_sync #(.W(1), .RST_VAL(1'b1)) u_shdn_sync (
    .clk (clk),
    .rst (rst),
    .d   (shutdown_n),
    .q   (shdn_s)
  );

  rail_seq_timer #(.TICK_DIV(TICK_DIV), .CW(CW)) u_timer (
    .clk   (clk),
    .rst   (rst),
    .run   (tmr_run),
    .limit (tmr_limit),
    .done  (tmr_done)
  );

  always_comb begin
    tmr_run   = 1'b1;
    tmr_limit = CW'(DLY_RAIL1);
    unique case (state_q)
      ST_ON1, ST_OFF1: tmr_limit = CW'(DLY_RAIL1);
      ST_ON2, ST_OFF2: tmr_limit = CW'(DLY_RAIL2);
      ST_ON3, ST_OFF3: tmr_limit = CW'(DLY_RAIL3);
      ST_SETTLE:       tmr_limit = CW'(DLY_SETTLE);
      ST_HOLDOFF:      tmr_limit = CW'(DLY_RELEASE);
      default:         tmr_run   = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_ON1;
      rail_en     <= '0;
      sys_reset_n <= 1'b0;
      fault       <= 1'b0;
    end else begin
      unique case (state_q)
        ST_ON1: if (tmr_done) begin
          rail_en[0] <= 1'b1;
          state_q    <= ST_ON2;
        end
        ST_ON2: if (tmr_done) begin
          rail_en[1] <= 1'b1;
          state_q    <= ST_ON3;
        end
        ST_ON3: if (tmr_done) begin
          rail_en[2] <= 1'b1;
          state_q    <= ST_SETTLE;
        end
        ST_SETTLE: if (tmr_done) begin
          if (&pg_s) begin
            state_q <= ST_HOLDOFF;
          end else begin
            fault   <= 1'b1;
            state_q <= ST_FAULT;
          end
        end
        ST_HOLDOFF: if (tmr_done) begin
          sys_reset_n <= 1'b1;
          state_q     <= ST_RUN;
        end
        ST_RUN: begin
          if (!(&pg_s)) begin
            fault       <= 1'b1;
            sys_reset_n <= 1'b0;
            state_q     <= ST_FAULT;
          end else if (!shdn_s) begin
            state_q <= ST_OFF1;
          end
        end
        ST_OFF1: if (tmr_done) begin
          rail_en[0] <= 1'b0;
          state_q    <= ST_OFF2;
        end
        ST_OFF2: if (tmr_done) begin
          rail_en[1] <= 1'b0;
          state_q    <= ST_OFF3;
        end
        ST_OFF3: if (tmr_done) begin
          rail_en[2]  <= 1'b0;
          sys_reset_n <= 1'b0;
          state_q     <= ST_IDLE;
        end
        ST_IDLE:  state_q <= ST_IDLE;
        ST_FAULT: state_q <= ST_FAULT;
        default: begin
          fault       <= 1'b1;
          sys_reset_n <= 1'b0;
          state_q     <= ST_FAULT;
        end
      endcase
    end
  end

  // R1: reset leaves all outputs inactive
  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (rail_en == 3'b000 && !sys_reset_n && !fault));

  // R2: rail 2 only rises with rail 1 on, rail 3 only with both on
  a_r2_rise_order2: assert property (@(posedge clk) disable iff (rst)
    $rose(rail_en[1]) |-> rail_en[0]);
  a_r2_rise_order3: assert property (@(posedge clk) disable iff (rst)
    $rose(rail_en[2]) |-> (rail_en[1:0] == 2'b11));

  // R5: reset is released only with every rail on and no fault
  a_r5_release_ok: assert property (@(posedge clk) disable iff (rst)
    $rose(sys_reset_n) |-> (rail_en == 3'b111 && !fault));

  // R7: a fault freezes the enables and keeps the system in reset
  a_r7_fault_latched: assert property (@(posedge clk) disable iff (rst)
    fault |=> (fault && $stable(rail_en) && !sys_reset_n));

  // R8: rails fall in order, system reset drops with the last one
  a_r8_fall_order2: assert property (@(posedge clk) disable iff (rst)
    $fell(rail_en[1]) |-> !rail_en[0]);
  a_r8_fall_order3: assert property (@(posedge clk) disable iff (rst)
    $fell(rail_en[2]) |-> (rail_en[1:0] == 2'b00 && !sys_reset_n));

  // R10: idle after power-down is terminal
  a_r10_idle_hold: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_IDLE) |=> (state_q == ST_IDLE && rail_en == 3'b000 && !sys_reset_n));

endmodule

// File: tb/rail_sequencer_tb.sv
module rail_sequencer_tb;

  localparam int unsigned TD  = 2;
  localparam int unsigned L1  = 4;
  localparam int unsigned L2  = 3;
  localparam int unsigned L3  = 5;
  localparam int unsigned LS  = 3;
  localparam int unsigned LR  = 2;
  localparam int T1   = L1 * TD;
  localparam int T2   = T1 + L2 * TD;
  localparam int T3   = T2 + L3 * TD;
  localparam int TSET = T3 + LS * TD;
  localparam int TREL = TSET + LR * TD;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] pwr_good = 3'b000;
  logic       shutdown_n = 1'b1;
  logic [2:0] rail_en;
  logic       sys_reset_n;
  logic       fault;

  int checks = 0;
  int fails  = 0;
  int now    = 0;
  bit ended  = 1'b0;

  always #2 clk = ~clk;

  rail_sequencer #(
    .TICK_DIV(TD), .DLY_RAIL1(L1), .DLY_RAIL2(L2), .DLY_RAIL3(L3),
    .DLY_SETTLE(LS), .DLY_RELEASE(LR)
  ) u_dut (
    .clk(clk), .rst(rst), .pwr_good(pwr_good), .shutdown_n(shutdown_n),
    .rail_en(rail_en), .sys_reset_n(sys_reset_n), .fault(fault)
  );

  task automatic chk(input string req, input logic [4:0] act, input logic [4:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s at cycle %0d: actual en/rst/fault=%b expected %b", req, now, act, exp);
    end
  endtask

  function automatic logic [4:0] outs();
    return {rail_en, sys_reset_n, fault};
  endfunction

  task automatic goto(input int t);
    while (now < t) begin
      @(negedge clk);
      now++;
    end
  endtask

  task automatic do_reset(input logic [2:0] pg, input logic sd);
    @(negedge clk);
    rst = 1'b1;
    pwr_good = pg;
    shutdown_n = sd;
    repeat (3) @(negedge clk);
    chk("R1 in reset", outs(), 5'b000_0_0);
    rst = 1'b0;
    now = 0;
    goto(1);
    chk("R1 after reset", outs(), 5'b000_0_0);
  endtask

  initial begin
    // Scenario A: normal power-up, then shutdown
    do_reset(3'b111, 1'b1);
    goto(T1 - 1); chk("R2 before rail1", outs(), 5'b000_0_0);
    goto(T1);     chk("R2 rail1 on", outs(), 5'b001_0_0);
    goto(T2 - 1); chk("R3 before rail2", outs(), 5'b001_0_0);
    goto(T2);     chk("R2 rail2 on", outs(), 5'b011_0_0);
    goto(T3 - 1); chk("R3 before rail3", outs(), 5'b011_0_0);
    goto(T3);     chk("R2 rail3 on", outs(), 5'b111_0_0);
    goto(TSET);   chk("R4 good sample no fault", outs(), 5'b111_0_0);
    goto(TREL - 1); chk("R5 before release", outs(), 5'b111_0_0);
    goto(TREL);   chk("R5 released", outs(), 5'b111_1_0);
    goto(40);
    shutdown_n = 1'b0;
    goto(42); chk("R11 shutdown not yet seen", outs(), 5'b111_1_0);
    goto(43 + T1 - 1); chk("R8 before rail1 off", outs(), 5'b111_1_0);
    goto(43 + T1);     chk("R8 rail1 off", outs(), 5'b110_1_0);
    goto(43 + T2 - 1); chk("R8 before rail2 off", outs(), 5'b110_1_0);
    goto(43 + T2);     chk("R8 rail2 off", outs(), 5'b100_1_0);
    goto(43 + T3 - 1); chk("R8 before rail3 off", outs(), 5'b100_1_0);
    goto(43 + T3);     chk("R8 rail3 off reset low", outs(), 5'b000_0_0);
    shutdown_n = 1'b1;
    pwr_good = 3'b000;
    goto(43 + T3 + 20); chk("R10 idle ignores inputs", outs(), 5'b000_0_0);
    pwr_good = 3'b111;
    shutdown_n = 1'b0;
    goto(43 + T3 + 40); chk("R10 idle still off", outs(), 5'b000_0_0);

    // Scenario B: each single bad power-good at the settle sample
    for (int k = 0; k < 3; k++) begin
      do_reset(3'b111 & ~(3'b001 << k), 1'b1);
      goto(T3);       chk("R2 rails on despite bad pg", outs(), 5'b111_0_0);
      goto(TSET - 1); chk("R4 before sample", outs(), 5'b111_0_0);
      goto(TSET);     chk("R4 bad pg faults", outs(), 5'b111_0_1);
      goto(TREL + 10); chk("R4 reset held low", outs(), 5'b111_0_1);
    end

    // Scenario C: power-good loss together with shutdown while running
    do_reset(3'b111, 1'b1);
    goto(40); chk("R5 running", outs(), 5'b111_1_0);
    pwr_good = 3'b011;
    shutdown_n = 1'b0;
    goto(42); chk("R11 loss not yet seen", outs(), 5'b111_1_0);
    goto(43); chk("R6 fault wins over shutdown", outs(), 5'b111_0_1);
    pwr_good = 3'b111;
    goto(43 + T3 + 10); chk("R7 fault latched", outs(), 5'b111_0_1);

    // Scenario D: shutdown held from reset is deferred to the running state
    do_reset(3'b111, 1'b0);
    goto(TREL);        chk("R9 release despite early shutdown", outs(), 5'b111_1_0);
    goto(TREL + 1 + T1 - 1); chk("R9 before rail1 off", outs(), 5'b111_1_0);
    goto(TREL + 1 + T1);     chk("R9 rail1 off", outs(), 5'b110_1_0);
    goto(TREL + 1 + T3);     chk("R9 all off", outs(), 5'b000_0_0);

    ended = 1'b1;
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!ended) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  %0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule